// File: doc/BRIEF.md
# Line-clock one-second pulse timer

The block issues one interval strobe per second for performance-monitoring counters. It takes its time base from a recovered line clock rather than from a local oscillator. Two framer channels each provide their recovered clock as a one-cycle enable tick in the common system clock domain. Channel A is the normal source. While channel A reports that its clock is lost, channel B's ticks are counted instead. The count carries on across a source change, so one interval may be built from ticks of both channels.

The terminal count depends on the line rate. A mode input picks the T1 limit or the E1 limit. The real values are 1,544,000 and 2,048,000 ticks, and both are parameters so that simulation can use short intervals. Both limits must be at least 2.

The strobe is controlled by a two-state machine:

- **COUNTING** is the state entered from reset. The output is low.
  - Transition *term_hit*: a selected tick arrives while the counter sits at or above its terminal value. The machine moves to STROBE.
- **STROBE** drives the output high.
  - Transition *strobe_done*: the next selected tick arrives. The machine returns to COUNTING.

The tick that ends the strobe is also counted as the first tick of the new interval. The output is therefore high for exactly one period of the selected line clock.

Top module: `sec_pulse_timer`

## Requirements
- R1: When `rst_n` is sampled low at a clock edge, the counter is cleared to zero and `sec_pulse` is low from the next cycle on. This holds even if ticks are present during reset.
- R2: While `lclk_lost_a` is 0, only `lclk_tick_a` advances the count. Ticks on `lclk_tick_b` have no effect on the count or on `sec_pulse`.
- R3: While `lclk_lost_a` is 1, only `lclk_tick_b` advances the count. Ticks on `lclk_tick_a` have no effect.
- R4: Changing `lclk_lost_a` does not clear the count. Ticks taken from A before the change and from B after it add up toward the same interval.
- R5: The terminal count is T1_TICKS when `mode_e1` = 0 and E1_TICKS when `mode_e1` = 1. `sec_pulse` rises one clock after the selected tick that completes that many ticks since reset or since the previous terminal tick.
- R6: Once high, `sec_pulse` stays high, for any number of system clocks, until the next selected tick. It falls one clock after that tick, and that tick counts as tick 1 of the new interval.
- R7: With no selected tick, the count holds and `sec_pulse` does not rise.
- R8: If `mode_e1` changes so that the count already stands at or beyond the new terminal value, the next selected tick is treated as terminal.
- R9: With a tick on every clock, `sec_pulse` is high for exactly one clock in every T1_TICKS clocks (T1 mode).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_e1 | input | 1 | Line-rate select: 0 = T1 limit, 1 = E1 limit |
| lclk_tick_a | input | 1 | One-cycle tick per recovered line-clock cycle, channel A |
| lclk_tick_b | input | 1 | One-cycle tick per recovered line-clock cycle, channel B |
| lclk_lost_a | input | 1 | Channel A loss-of-clock indication; when 1, channel B is counted |
| sec_pulse | output | 1 | Interval strobe, active high, one selected line-clock period wide |

## Verification
A wrong count shows up at the next terminal tick. The strobe then rises early or late relative to the reference model, and the error is visible within one interval of the fault. A wrong state in the strobe machine shows up sooner: the output either stays high past the next selected tick or fails to rise one clock after a terminal tick, so the mismatch is seen within one selected-tick gap. Source-selection faults are exposed by runs that tick only the channel that should be ignored. Any ticks counted from that channel move the next strobe earlier.

// File: rtl/sec_pkg.sv
package sec_pkg;

    // Strobe machine states
    typedef enum logic {
        ST_COUNTING = 1'b0,
        ST_STROBE   = 1'b1
    } strobe_state_t;

    // Which line clock is currently feeding the counter
    typedef enum logic {
        SRC_CHAN_A = 1'b0,
        SRC_CHAN_B = 1'b1
    } tick_src_t;

endpackage

// File: rtl/sec_src_sel.sv
module sec_src_sel
    import sec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_a,
    input  logic      tick_b,
    input  logic      lost_a,
    output logic      tick_sel,
    output tick_src_t src
);

    always_comb begin
        src = lost_a ? SRC_CHAN_B : SRC_CHAN_A;
    end

    always_comb begin
        unique case (src)
            SRC_CHAN_A: tick_sel = tick_a;
            SRC_CHAN_B: tick_sel = tick_b;
            default:    tick_sel = 1'b0;
        endcase
    end

    // R2
    a_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lost_a && !tick_a) |-> !tick_sel);

    // R3
    b_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_a && !tick_b) |-> !tick_sel);

endmodule

// File: rtl/sec_tick_counter.sv
module sec_tick_counter #(
    parameter int T1_TICKS = 1544000,
    parameter int E1_TICKS = 2048000,
    parameter int CW       = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          mode_e1,
    output logic [CW-1:0] count,
    output logic          at_end
);

    localparam logic [CW-1:0] T1_LAST = CW'(T1_TICKS - 1);
    localparam logic [CW-1:0] E1_LAST = CW'(E1_TICKS - 1);

    logic [CW-1:0] last_val;

    always_comb begin
        last_val = mode_e1 ? E1_LAST : T1_LAST;
        // At or beyond: a shrink of the limit mid-interval ends it on the next tick
        at_end   = (count >= last_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            if (at_end) begin
                count <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    // R7
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_end) |=> (count == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0));

endmodule

// File: rtl/sec_strobe_fsm.sv
module sec_strobe_fsm
    import sec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic at_end,
    output logic pulse
);

    strobe_state_t state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNTING: if (tick && at_end) state_d = ST_STROBE;   // term_hit
            ST_STROBE:   if (tick)           state_d = ST_COUNTING; // strobe_done
            default:                         state_d = ST_COUNTING;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_COUNTING;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_STROBE:   pulse = 1'b1;
            ST_COUNTING: pulse = 1'b0;
            default:     pulse = 1'b0;
        endcase
    end

    // R5
    rise_on_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_end && !pulse) |=> pulse);

    // R6
    fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && tick) |=> !pulse);

    // R6
    hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !tick) |=> pulse);

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> !pulse);

endmodule

// File: rtl/sec_pulse_timer.sv
module sec_pulse_timer
    import sec_pkg::*;
#(
    parameter int T1_TICKS = 1544000,
    parameter int E1_TICKS = 2048000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_e1,
    input  logic lclk_tick_a,
    input  logic lclk_tick_b,
    input  logic lclk_lost_a,
    output logic sec_pulse
);

    localparam int MAX_TICKS = (T1_TICKS > E1_TICKS) ? T1_TICKS : E1_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);

    logic          tick_sel;
    tick_src_t     src;
    logic [CW-1:0] count;
    logic          at_end;

    sec_src_sel u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_a   (lclk_tick_a),
        .tick_b   (lclk_tick_b),
        .lost_a   (lclk_lost_a),
        .tick_sel (tick_sel),
        .src      (src)
    );

    sec_tick_counter #(
        .T1_TICKS (T1_TICKS),
        .E1_TICKS (E1_TICKS),
        .CW       (CW)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_sel),
        .mode_e1 (mode_e1),
        .count   (count),
        .at_end  (at_end)
    );

    sec_strobe_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_sel),
        .at_end (at_end),
        .pulse  (sec_pulse)
    );

    // R3
    ignore_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_CHAN_B && !lclk_tick_b) |=> $stable(count));

    // R2
    ignore_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_CHAN_A && !lclk_tick_a) |=> ($stable(count) && $stable(sec_pulse)));

    // R4
    switch_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lclk_lost_a) != lclk_lost_a && !tick_sel) |=> $stable(count));

endmodule

// File: tb/sec_pulse_timer_test.sv
`timescale 1ns/1ps
module sec_pulse_timer_test;

    localparam int T1L = 12;
    localparam int E1L = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_e1 = 1'b0;
    logic ta = 1'b0;
    logic tb = 1'b0;
    logic lost = 1'b0;
    logic sec_pulse;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit started = 0;

    // Reference model state
    int  m_cnt = 0;
    bit  m_pulse = 0;

    always #2.5 clk = ~clk;

    sec_pulse_timer #(.T1_TICKS(T1L), .E1_TICKS(E1L)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_e1     (mode_e1),
        .lclk_tick_a (ta),
        .lclk_tick_b (tb),
        .lclk_lost_a (lost),
        .sec_pulse   (sec_pulse)
    );

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: sec_pulse=%0b expected=%0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Behavioural reference, updated on every edge
    always @(posedge clk) begin
        int lim;
        bit t;
        cyc++;
        lim = mode_e1 ? E1L : T1L;
        t = lost ? tb : ta;
        if (!rst_n) begin
            m_cnt = 0;
            m_pulse = 0;
        end else if (t) begin
            m_pulse = 0;
            m_cnt = m_cnt + 1;
            if (m_cnt >= lim) begin
                m_cnt = 0;
                m_pulse = 1;
            end
        end
        if (cyc > 20000) begin
            bad++;
            $display("FAIL watchdog: sec_pulse=%0b expected=finish", sec_pulse);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Per-cycle comparison against the model (R5, R6)
    always @(negedge clk) begin
        if (started) check(sec_pulse, m_pulse, "R6 model");
    end

    task automatic step(input logic a, input logic b);
        ta = a;
        tb = b;
        @(posedge clk);
        @(negedge clk);
        ta = 1'b0;
        tb = 1'b0;
    endtask

    task automatic ticks_a(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0);
            step(1'b0, 1'b0);
        end
    endtask

    task automatic ticks_b(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b1);
        end
    endtask

    task automatic do_reset(input logic with_ticks);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step(with_ticks, with_ticks);
        rst_n = 1'b1;
    endtask

    initial begin
        int highs;
        @(negedge clk);
        do_reset(1'b0);
        started = 1;
        // R1: reset state
        check(sec_pulse, 1'b0, "R1 reset");

        // R5: T1 interval
        ticks_a(T1L - 1);
        check(sec_pulse, 1'b0, "R5 before terminal");
        step(1'b1, 1'b0);
        check(sec_pulse, 1'b1, "R5 terminal T1");
        // R6: hold until next tick
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
        check(sec_pulse, 1'b1, "R6 held");
        step(1'b1, 1'b0);
        check(sec_pulse, 1'b0, "R6 fall");  // count now 1

        // R2: channel B ignored while A is good
        ticks_b(30);
        check(sec_pulse, 1'b0, "R2 b ignored");
        ticks_a(T1L - 2);
        check(sec_pulse, 1'b0, "R2 count intact");
        step(1'b1, 1'b0);
        check(sec_pulse, 1'b1, "R2 terminal");
        step(1'b1, 1'b0);                   // count 1

        // R3 / R4: failover mid-interval
        ticks_a(5);                         // count 6
        lost = 1'b1;
        ticks_a(20);
        check(sec_pulse, 1'b0, "R3 a ignored");
        ticks_b(5);                         // count 11
        check(sec_pulse, 1'b0, "R4 before terminal");
        ticks_b(1);
        check(sec_pulse, 1'b1, "R4 total across switch");
        lost = 1'b0;
        step(1'b1, 1'b0);                   // count 1

        // R7: idle holds
        for (int i = 0; i < 50; i++) step(1'b0, 1'b0);
        check(sec_pulse, 1'b0, "R7 idle");
        ticks_a(T1L - 2);
        check(sec_pulse, 1'b0, "R7 held count");
        step(1'b1, 1'b0);
        check(sec_pulse, 1'b1, "R7 terminal after idle");
        step(1'b1, 1'b0);                   // count 1

        // R5: E1 interval
        mode_e1 = 1'b1;
        ticks_a(E1L - 2);
        check(sec_pulse, 1'b0, "R5 E1 before terminal");
        step(1'b1, 1'b0);
        check(sec_pulse, 1'b1, "R5 terminal E1");
        step(1'b1, 1'b0);                   // count 1

        // R8: limit shrinks below count
        ticks_a(13);                        // count 14
        check(sec_pulse, 1'b0, "R8 beyond T1 in E1");
        mode_e1 = 1'b0;
        step(1'b1, 1'b0);
        check(sec_pulse, 1'b1, "R8 next tick terminal");

        // R9: continuous ticks
        do_reset(1'b0);
        highs = 0;
        for (int i = 0; i < 4 * T1L; i++) begin
            step(1'b1, 1'b0);
            if (sec_pulse) highs++;
        end
        total++;
        if (highs != 4) begin
            bad++;
            $display("FAIL R9: high cycles=%0d expected=4", highs);
        end

        // R1: reset mid-interval with ticks present
        ticks_a(7);
        do_reset(1'b1);
        check(sec_pulse, 1'b0, "R1 reset mid");
        ticks_a(T1L - 1);
        check(sec_pulse, 1'b0, "R1 count cleared");
        step(1'b1, 1'b0);
        check(sec_pulse, 1'b1, "R1 full interval after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule